// File: doc/BRIEF.md
# UART Wake-up and DMA Request Control

This block sits next to a UART core and holds one 8-bit control register. It watches the receive line and the active-low clear-to-send and data-set-ready lines. When wake-up detection is enabled and any of them falls, it sets a sticky wake status bit and raises a wake interrupt. Software reads the status bit when the core's interrupt identification shows nothing pending. The only way to clear the status is to disable detection.

The same register selects where the DMA mode comes from. The mode can follow a legacy bit of the FIFO control register, or a two-bit field in this register. The block routes the core's transmit and receive DMA needs onto two active-low request lines according to that mode. It also selects the condition that raises the transmit-holding interrupt. The enable bit for the data-set-ready change interrupt and the two trigger-granularity bits are passed to the core as plain outputs.

Top module: `uart_wake_dma_ctl`

## Requirements
- R1: The control register resets to 0. A write sets all of bits 7:0, and bits 31:8 of the read data are always 0.
- R2: While bit 4 is 1, a falling edge on `rx_i`, `cts_ni` or `dsr_ni` sets `wake_sts_o` and `wake_irq_o`. The pin falls before clock edge k; the outputs become 1 after edge k+2, because of two synchronizer flops and one status flop.
- R3: While bit 4 is 0, pin falls never set `wake_sts_o`.
- R4: A write with bit 4 = 0 clears `wake_sts_o` and `wake_irq_o` on the same clock edge that updates the register.
- R5: Once set, `wake_sts_o` stays 1 until bit 4 is written to 0, whatever the pins do afterwards.
- R6: Bit 0 selects the mode source. With bit 0 = 0, the mode is 0 if `fcr_dma_mode_i` is 0 and 1 if it is 1. With bit 0 = 1, the mode is bits 2:1.
- R7: Mode 1 drives `dma_req_no[0]` = ~`tx_dma_need_i` and `dma_req_no[1]` = ~`rx_dma_need_i`. Mode 2 drives `dma_req_no[0]` = ~`rx_dma_need_i`. Mode 3 drives `dma_req_no[0]` = ~`tx_dma_need_i`. In modes 2 and 3, `dma_req_no[1]` is 1. Routing is combinational.
- R8: In mode 0, `dma_req_no` is 2'b11.
- R9: With bit 3 = 1, `thr_irq_o` = `tx_fifo_empty_i` & `tx_shift_empty_i`. With bit 3 = 0, `thr_irq_o` = `thr_level_i`.
- R10: `dsr_irq_en_o`, `tx_gran1_o` and `rx_gran1_o` reflect bits 5, 6 and 7 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Control register read data |
| rx_i | input | 1 | Receive line level |
| cts_ni | input | 1 | Clear-to-send level, active low |
| dsr_ni | input | 1 | Data-set-ready level, active low |
| tx_fifo_empty_i | input | 1 | Transmit FIFO empty |
| tx_shift_empty_i | input | 1 | Transmit shift register empty |
| thr_level_i | input | 1 | Normal FIFO-level transmit-holding condition |
| tx_dma_need_i | input | 1 | Transmit side needs DMA service |
| rx_dma_need_i | input | 1 | Receive side needs DMA service |
| fcr_dma_mode_i | input | 1 | Legacy DMA-mode bit from FIFO control |
| wake_sts_o | output | 1 | Sticky wake status |
| wake_irq_o | output | 1 | Wake interrupt |
| thr_irq_o | output | 1 | Transmit-holding interrupt condition |
| dma_req_no | output | 2 | DMA request lines, active low |
| dsr_irq_en_o | output | 1 | Data-set-ready change interrupt enable |
| tx_gran1_o | output | 1 | Single-entry transmit trigger granularity |
| rx_gran1_o | output | 1 | Single-entry receive trigger granularity |

## Verification
On every cycle, the assertions check the following:
- the zero upper read bits;
- that a disabled enable implies a clear status;
- that status cannot rise without the enable;
- that status stays sticky;
- idle-high requests in mode 0;
- that line 1 is used only in mode 1;
- that in the end-of-transmit setting the transmit-holding interrupt needs both empty flags.

Only the bench scenarios can show these:
- the exact three-edge wake latency through the synchronizers;
- the mapping from the legacy bit to a mode;
- the need-to-line routing in each mode;
- the granularity outputs.

The bench compares every output against its reference model on every cycle.

// File: rtl/uart_wdc_pkg.sv
package uart_wdc_pkg;
  localparam int CTRL_W = 8;

  localparam int B_MODE_SRC = 0;
  localparam int B_MODE_LO  = 1;
  localparam int B_THR_END  = 3;
  localparam int B_WAKE_EN  = 4;
  localparam int B_DSR_IE   = 5;
  localparam int B_TX_G1    = 6;
  localparam int B_RX_G1    = 7;

  typedef enum logic [1:0] {
    DMA_OFF   = 2'd0,
    DMA_SPLIT = 2'd1,
    DMA_RX0   = 2'd2,
    DMA_TX0   = 2'd3
  } dma_mode_e;
endpackage

// File: rtl/uart_wdc_pin_sync.sv
module uart_wdc_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {DEPTH{RST_VAL}};
    else         sh_q <= {sh_q[DEPTH-2:0], pin_i};
  end

  // last synced sample low, one before high
  assign fall_o = sh_q[DEPTH-1] & ~sh_q[DEPTH-2];
endmodule

// File: rtl/uart_wdc_ctrl_reg.sv
module uart_wdc_ctrl_reg
  import uart_wdc_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              any_fall_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              sts_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              sts_q, en_nxt;

  assign en_nxt = we_i ? wdata_i[B_WAKE_EN] : ctrl_q[B_WAKE_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sts_q  <= 1'b0;
    end else begin
      if (we_i) ctrl_q <= wdata_i[CTRL_W-1:0];
      // disabling clears on the same edge as the write
      sts_q <= en_nxt & (sts_q | (ctrl_q[B_WAKE_EN] & any_fall_i));
    end
  end

  assign ctrl_o = ctrl_q;
  assign sts_o  = sts_q;
endmodule

// File: rtl/uart_wdc_dma_route.sv
module uart_wdc_dma_route
  import uart_wdc_pkg::*;
(
  input  logic       src_field_i,
  input  logic [1:0] field_i,
  input  logic       legacy_i,
  input  logic       tx_need_i,
  input  logic       rx_need_i,
  output logic [1:0] req_no
);
  dma_mode_e mode;

  always_comb begin
    mode = src_field_i ? dma_mode_e'(field_i)
                       : (legacy_i ? DMA_SPLIT : DMA_OFF);
    req_no = 2'b11;
    unique case (mode)
      DMA_SPLIT: req_no = {~rx_need_i, ~tx_need_i};
      DMA_RX0:   req_no[0] = ~rx_need_i;
      DMA_TX0:   req_no[0] = ~tx_need_i;
      default:   req_no = 2'b11;
    endcase
  end
endmodule

// File: rtl/uart_wake_dma_ctl.sv
module uart_wake_dma_ctl
  import uart_wdc_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             rx_i,
  input  logic             cts_ni,
  input  logic             dsr_ni,
  input  logic             tx_fifo_empty_i,
  input  logic             tx_shift_empty_i,
  input  logic             thr_level_i,
  input  logic             tx_dma_need_i,
  input  logic             rx_dma_need_i,
  input  logic             fcr_dma_mode_i,
  output logic             wake_sts_o,
  output logic             wake_irq_o,
  output logic             thr_irq_o,
  output logic [1:0]       dma_req_no,
  output logic             dsr_irq_en_o,
  output logic             tx_gran1_o,
  output logic             rx_gran1_o
);
  localparam int NPIN = 3;

  logic [NPIN-1:0]   pins, falls;
  logic [CTRL_W-1:0] ctrl;
  logic              sts;

  assign pins = {dsr_ni, cts_ni, rx_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    uart_wdc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pins[g]),
      .fall_o(falls[g])
    );
  end

  uart_wdc_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .any_fall_i(|falls),
    .ctrl_o    (ctrl),
    .sts_o     (sts)
  );

  uart_wdc_dma_route u_dma (
    .src_field_i(ctrl[B_MODE_SRC]),
    .field_i    (ctrl[B_MODE_LO+1:B_MODE_LO]),
    .legacy_i   (fcr_dma_mode_i),
    .tx_need_i  (tx_dma_need_i),
    .rx_need_i  (rx_dma_need_i),
    .req_no     (dma_req_no)
  );

  assign reg_rdata_o  = {{(REG_W-CTRL_W){1'b0}}, ctrl};
  assign wake_sts_o   = sts;
  assign wake_irq_o   = sts & ctrl[B_WAKE_EN];
  assign thr_irq_o    = ctrl[B_THR_END] ? (tx_fifo_empty_i & tx_shift_empty_i)
                                        : thr_level_i;
  assign dsr_irq_en_o = ctrl[B_DSR_IE];
  assign tx_gran1_o   = ctrl[B_TX_G1];
  assign rx_gran1_o   = ctrl[B_RX_G1];
endmodule

// File: rtl/uart_wdc_chk.sv
module uart_wdc_chk #(
  parameter int REG_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             wake_sts_o,
  input logic             thr_irq_o,
  input logic             tx_fifo_empty_i,
  input logic             tx_shift_empty_i,
  input logic             fcr_dma_mode_i,
  input logic [1:0]       dma_req_no
);
  logic [1:0] mode;
  assign mode = reg_rdata_o[0] ? reg_rdata_o[2:1] : {1'b0, fcr_dma_mode_i};

  a_r1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:8] == '0);

  a_r4_clear_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[4] |-> !wake_sts_o);

  a_r3_no_rise_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[4] |=> !wake_sts_o);

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_sts_o && !(reg_we_i && !reg_wdata_i[4])) |=> wake_sts_o);

  a_r8_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == 2'd0 |-> dma_req_no == 2'b11);

  a_r7_line1_mode1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_req_no[1] |-> mode == 2'd1);

  a_r9_thr_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[3] && thr_irq_o) |-> (tx_fifo_empty_i && tx_shift_empty_i));
endmodule

bind uart_wake_dma_ctl uart_wdc_chk #(.REG_W(REG_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_we_i        (reg_we_i),
  .reg_wdata_i     (reg_wdata_i),
  .reg_rdata_o     (reg_rdata_o),
  .wake_sts_o      (wake_sts_o),
  .thr_irq_o       (thr_irq_o),
  .tx_fifo_empty_i (tx_fifo_empty_i),
  .tx_shift_empty_i(tx_shift_empty_i),
  .fcr_dma_mode_i  (fcr_dma_mode_i),
  .dma_req_no      (dma_req_no)
);

// File: tb/sim_uart_wake_dma_ctl.sv
`timescale 1ns/1ps
module sim_uart_wake_dma_ctl;
  logic        clk = 0, rst_n = 0;
  logic        we = 0;
  logic [31:0] wdata = 0, rdata;
  logic        rx = 1, cts_n = 1, dsr_n = 1;
  logic        txe = 0, tse = 0, lvl = 0, txn = 0, rxn = 0, fcr = 0;
  logic        sts, irq, thr, dsrie, txg, rxg;
  logic [1:0]  req_n;

  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  uart_wake_dma_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .rx_i(rx), .cts_ni(cts_n), .dsr_ni(dsr_n),
    .tx_fifo_empty_i(txe), .tx_shift_empty_i(tse), .thr_level_i(lvl),
    .tx_dma_need_i(txn), .rx_dma_need_i(rxn), .fcr_dma_mode_i(fcr),
    .wake_sts_o(sts), .wake_irq_o(irq), .thr_irq_o(thr), .dma_req_no(req_n),
    .dsr_irq_en_o(dsrie), .tx_gran1_o(txg), .rx_gran1_o(rxg)
  );

  // reference model
  int       m_ctrl;
  bit       m_sts;
  bit [2:0] q_pins[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_sts = 0;
      q_pins = '{3'b111, 3'b111, 3'b111};
    end else begin
      bit fell; bit en_next;
      fell = 0;
      for (int p = 0; p < 3; p++)
        if (q_pins[2][p] && !q_pins[1][p]) fell = 1;
      en_next = we ? wdata[4] : m_ctrl[4];
      if (!en_next) m_sts = 0;
      else if (m_ctrl[4] && fell) m_sts = 1;
      if (we) m_ctrl = int'(wdata[7:0]);
      q_pins.push_front({dsr_n, cts_n, rx});
      void'(q_pins.pop_back());
    end
  end

  function automatic int exp_mode();
    if (m_ctrl[0]) return (m_ctrl >> 1) & 3;
    return fcr ? 1 : 0;
  endfunction

  function automatic bit [1:0] exp_req();
    case (exp_mode())
      1: return {~rxn, ~txn};
      2: return {1'b1, ~rxn};
      3: return {1'b1, ~txn};
      default: return 2'b11;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R1 rdata", int'(rdata), m_ctrl);
      chk("R2 sts", int'(sts), int'(m_sts));
      chk("R2 irq", int'(irq), int'(m_sts & m_ctrl[4]));
      chk("R7 req", int'(req_n), int'(exp_req()));
      chk("R9 thr", int'(thr), m_ctrl[3] ? int'(txe & tse) : int'(lvl));
      chk("R10 flags", int'({rxg, txg, dsrie}), (m_ctrl >> 5) & 7);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk); we = 1; wdata = v;
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic probe();
    @(posedge clk); #2;
  endtask

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1;
    probe();
    chk("R1 reset ctrl", int'(rdata), 0);
    chk("R8 reset req idle", int'(req_n), 3);

    // R1 all bits written, upper read zero
    wr(32'hFFFF_FFFF);
    probe(); chk("R1 readback", int'(rdata), 32'hFF);
    chk("R10 flags set", int'({rxg, txg, dsrie}), 7);
    wr(32'h0);

    // R3 fall while disabled
    @(negedge clk); rx = 0;
    cyc(4); probe(); chk("R3 no wake when off", int'(sts), 0);
    @(negedge clk); rx = 1; cyc(4);

    // R2 exact latency on dsr
    wr(32'h10); cyc(2);
    @(negedge clk); dsr_n = 0;      // before edge k
    probe(); probe();               // after k, k+1
    chk("R2 not yet", int'(sts), 0);
    probe();                        // after k+2
    chk("R2 sts set", int'(sts), 1);
    chk("R2 irq set", int'(irq), 1);

    // R5 sticky through pin rise and other writes
    @(negedge clk); dsr_n = 1;
    wr(32'h18); cyc(3);
    probe(); chk("R5 sticky", int'(sts), 1);

    // R4 disable clears on write edge
    @(negedge clk); we = 1; wdata = 32'h0;
    probe(); chk("R4 cleared", int'(sts), 0);
    chk("R4 irq cleared", int'(irq), 0);
    @(negedge clk); we = 0;

    // R2 on cts
    wr(32'h10); cyc(2);
    @(negedge clk); cts_n = 0;
    cyc(4); probe(); chk("R2 cts wake", int'(sts), 1);
    @(negedge clk); cts_n = 1;
    wr(32'h0);

    // R6 legacy source
    @(negedge clk); fcr = 0; txn = 1; rxn = 1;
    probe(); chk("R8 legacy 0 idle", int'(req_n), 3);
    @(negedge clk); fcr = 1;
    probe(); chk("R6 legacy 1 -> mode1", int'(req_n), 0);
    @(negedge clk); rxn = 0;
    probe(); chk("R6 mode1 tx only", int'(req_n), 2);

    // R7 field modes, legacy ignored
    for (int m = 0; m < 4; m++) begin
      for (int pat = 0; pat < 4; pat++) begin
        wr(32'h1 | (m << 1));
        @(negedge clk); txn = pat[0]; rxn = pat[1]; fcr = ~fcr;
        probe();
        chk("R7 field mode", int'(req_n), int'(exp_req()));
      end
    end
    wr(32'h1);
    probe(); chk("R8 field mode0 idle", int'(req_n), 3);

    // R9 thr source
    wr(32'h0);
    @(negedge clk); lvl = 1; txe = 0; tse = 0;
    probe(); chk("R9 level mode", int'(thr), 1);
    wr(32'h8);
    probe(); chk("R9 end mode not empty", int'(thr), 0);
    @(negedge clk); txe = 1;
    probe(); chk("R9 fifo only", int'(thr), 0);
    @(negedge clk); tse = 1; lvl = 0;
    probe(); chk("R9 both empty", int'(thr), 1);

    cyc(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule